// File: doc/BRIEF.md
# Burst-of-Four Shared-Bus SRAM Controller

This block sits between a simple request stream and a synchronous SRAM that moves data on both clock edges in fixed bursts of four beats over a single bidirectional data bus. Each request names an address, a direction, four write words and a per-beat, per-byte enable mask. A read returns its four words together as one response pulse. The controller runs on a clock at twice the memory clock rate. It generates the memory clock pair, schedules commands so that address and control are stable across the rising memory clock edge, serialises write beats one system cycle apart with late-write timing, and captures read beats a fixed number of half memory cycles after the command.

The request side is valid/ready. A request is taken on a rising `clk` edge where `req_valid` and `req_ready` are both high, and the fields must stay stable while `req_valid` is high and `req_ready` is low. `req_ready` depends on internal state and on `req_write`, never on `req_valid`. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse and the user must take the data in that cycle. `RD_LAT` must be at least 2.

Top module: `sram_b4_ctrl`

## Requirements
- R1: Every burst starts on a four-word boundary: while a command is driven, `mem_addr` equals `req_addr` with its two low bits forced to zero. A read of any address in the group returns the four words of that aligned group.
- R2: `req_ready` is low during reset. It can only be high on alternate `clk` cycles: those in which the next `mem_k` edge is a rising one. At most one request is taken per four `clk` cycles.
- R3: For each accepted request, exactly one command is seen at a rising `mem_k` edge. `mem_rd_n` (reads) or `mem_wr_n` (writes) goes low for two `clk` cycles with `mem_addr` held, then returns high.
- R4: `mem_k` toggles on every falling `clk` edge, so its period is two `clk` cycles. `mem_kn` is always its complement. The rising `mem_k` edge falls half a `clk` cycle after the command pins change.
- R5: Write data is late. Beat b (b = 0..3) is driven onto `mem_dq` during the `clk` cycle that starts 2+b rising edges after acceptance. Beats 0 and 2 sit across a rising `mem_k` edge, and beats 1 and 3 across a rising `mem_kn` edge.
- R6: `mem_bw_n[i]` is low exactly when `req_be[b*BYTES+i]` was set for the beat being driven. It is all ones when no beat is driven. A masked byte leaves memory unchanged.
- R7: Read beat b is sampled on the rising `clk` edge RD_LAT+1+b edges after acceptance. `rsp_valid` pulses for one cycle RD_LAT+4 edges after acceptance. `rsp_rdata` holds beat 0 in its least significant word.
- R8: The controller drives `mem_dq` only while driving write beats. It never drives the bus in a cycle in which a read beat is sampled.
- R9: A write that follows a read is accepted no sooner than 2*ceil((RD_LAT+5)/2) `clk` cycles after it (8 by default). This leaves at least one idle memory cycle between the last read beat and the first write beat.
- R10: Read after read, write after write and read after write can be accepted every four `clk` cycles, giving a continuous stream of beats.
- R11: During reset `mem_rd_n`, `mem_wr_n` and all of `mem_bw_n` are high, `rsp_valid` is low and `mem_dq` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the memory clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Word address (low two bits ignored) |
| req_wdata | input | 4*BYTE_W*BYTES | Four write words, beat 0 in low bits |
| req_be | input | 4*BYTES | Byte enables, bit b*BYTES+i for lane i of beat b, 1 = write |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 4*BYTE_W*BYTES | Four read words, beat 0 in low bits |
| mem_k | output | 1 | Memory clock |
| mem_kn | output | 1 | Complement memory clock |
| mem_addr | output | ADDR_W | Burst address to memory |
| mem_rd_n | output | 1 | Active-low read select |
| mem_wr_n | output | 1 | Active-low write select |
| mem_bw_n | output | BYTES | Active-low byte-write selects for current beat |
| mem_dq | inout | BYTE_W*BYTES | Shared data bus |

## Verification
The hardest case to reach is the bus handover at the tightest spacing the scheduler allows. One example is a write that enters right behind a read, while the memory is still driving the last read beats. Another is a read that enters while the previous write's last beats are still on the bus. The bench keeps `req_valid` asserted across successive requests of mixed direction, so every request is taken at the earliest slot the handshake offers. A bench-side memory model drives read beats with the configured latency and flags any cycle in which the bus carries something other than what it drove. Measured acceptance spacings and response arrival cycles are compared with the numbers the requirements give.

// File: rtl/sb4_pkg.sv
package sb4_pkg;
  localparam int BEATS  = 4;
  localparam int BEAT_W = 2;
endpackage

// File: rtl/sb4_kgen.sv
module sb4_kgen (
  input  logic clk,
  input  logic rst_n,
  output logic ph,
  output logic mem_k
);
  // ph = 1 in the cycle whose falling edge raises mem_k
  always_ff @(posedge clk) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  always_ff @(negedge clk) begin
    if (!rst_n) mem_k <= 1'b0;
    else        mem_k <= ph;
  end
endmodule

// File: rtl/sb4_sched.sv
module sb4_sched #(
  parameter int ADDR_W = 20,
  parameter int RD_LAT = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ph,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      req_ready,
  output logic                      accept_wr,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_rd_n,
  output logic                      mem_wr_n,
  output logic [sb4_pkg::BEATS-1:0] cap,
  output logic [sb4_pkg::BEATS-1:0] drv
);
  localparam int BEATS   = sb4_pkg::BEATS;
  localparam int GAP     = ((RD_LAT + 6) / 2) * 2;
  localparam int SINCE_W = $clog2(GAP + 1);
  localparam int RW_MIN  = GAP - 1;
  localparam int STD_MIN = BEATS - 1;
  localparam int RP_W    = RD_LAT + BEATS;

  logic [SINCE_W-1:0] since_q;
  logic               last_rd_q;
  logic               accept;
  logic [RP_W-1:0]    rd_pipe;
  logic [BEATS:0]     wr_pipe;

  always_comb begin
    if (last_rd_q && req_write)
      req_ready = rst_n && !ph && (since_q >= SINCE_W'(RW_MIN));
    else
      req_ready = rst_n && !ph && (since_q >= SINCE_W'(STD_MIN));
  end

  assign accept    = req_valid && req_ready;
  assign accept_wr = accept && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q   <= SINCE_W'(RW_MIN);
      last_rd_q <= 1'b0;
    end else if (accept) begin
      since_q   <= '0;
      last_rd_q <= !req_write;
    end else if (since_q < SINCE_W'(RW_MIN)) begin
      since_q   <= since_q + 1'b1;
    end
  end

  // command pins change only in cycles ahead of a rising mem_k
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_rd_n <= 1'b1;
      mem_wr_n <= 1'b1;
    end else if (!ph) begin
      if (accept) begin
        mem_addr <= req_addr & ~ADDR_W'(3);
        mem_rd_n <= req_write;
        mem_wr_n <= !req_write;
      end else begin
        mem_rd_n <= 1'b1;
        mem_wr_n <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pipe <= '0;
      wr_pipe <= '0;
    end else begin
      rd_pipe <= {rd_pipe[RP_W-2:0], accept && !req_write};
      wr_pipe <= {wr_pipe[BEATS-1:0], accept_wr};
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_tap
    assign cap[b] = rd_pipe[RD_LAT + b];
    assign drv[b] = wr_pipe[1 + b];
  end

  AST_ONE_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);  // R2
endmodule

// File: rtl/sb4_wpath.sv
module sb4_wpath #(
  parameter int BYTE_W = 9,
  parameter int BYTES  = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     load,
  input  logic [sb4_pkg::BEATS*BYTE_W*BYTES-1:0]   wdata,
  input  logic [sb4_pkg::BEATS*BYTES-1:0]          wbe,
  input  logic [sb4_pkg::BEATS-1:0]                drv,
  output logic [BYTE_W*BYTES-1:0]                  dq_out,
  output logic                                     dq_oe,
  output logic [BYTES-1:0]                         bw_n
);
  localparam int BEATS = sb4_pkg::BEATS;
  localparam int DW    = BYTE_W * BYTES;

  logic [BEATS*DW-1:0]    wq, wsh;
  logic [BEATS*BYTES-1:0] bq, bsh;
  logic [DW-1:0]          nd;
  logic [BYTES-1:0]       nb;
  logic                   noe;

  // two stages so a new write can be taken while the old one drains
  always_ff @(posedge clk) begin
    if (load) begin
      wq <= wdata;
      bq <= wbe;
    end
    if (drv[0]) begin
      wsh <= wq;
      bsh <= bq;
    end
  end

  always_comb begin
    nd  = '0;
    nb  = '1;
    noe = 1'b0;
    for (int b = 0; b < BEATS; b++) begin
      if (drv[b]) begin
        noe = 1'b1;
        if (b == 0) begin
          nd = wq[b*DW +: DW];
          nb = ~bq[b*BYTES +: BYTES];
        end else begin
          nd = wsh[b*DW +: DW];
          nb = ~bsh[b*BYTES +: BYTES];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
      bw_n   <= '1;
    end else begin
      dq_out <= nd;
      dq_oe  <= noe;
      bw_n   <= nb;
    end
  end

  AST_BW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (bw_n == '1));  // R6
endmodule

// File: rtl/sb4_rpath.sv
module sb4_rpath #(
  parameter int DW = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [sb4_pkg::BEATS-1:0]    cap,
  input  logic [DW-1:0]                dq_in,
  output logic                         rsp_valid,
  output logic [sb4_pkg::BEATS*DW-1:0] rsp_rdata
);
  localparam int BEATS = sb4_pkg::BEATS;

  logic [DW-1:0]       beat_q [BEATS-1];
  logic [BEATS*DW-1:0] whole;

  for (genvar b = 0; b < BEATS - 1; b++) begin : g_cap
    always_ff @(posedge clk) begin
      if (cap[b]) beat_q[b] <= dq_in;
    end
    assign whole[b*DW +: DW] = beat_q[b];
  end
  assign whole[(BEATS-1)*DW +: DW] = dq_in;

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= cap[BEATS-1];
    if (cap[BEATS-1]) rsp_rdata <= whole;
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R7
endmodule

// File: rtl/sram_b4_ctrl.sv
module sram_b4_ctrl #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 9,
  parameter int BYTES  = 2,
  parameter int RD_LAT = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [4*BYTE_W*BYTES-1:0]   req_wdata,
  input  logic [4*BYTES-1:0]          req_be,
  output logic                        rsp_valid,
  output logic [4*BYTE_W*BYTES-1:0]   rsp_rdata,
  output logic                        mem_k,
  output logic                        mem_kn,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic                        mem_rd_n,
  output logic                        mem_wr_n,
  output logic [BYTES-1:0]            mem_bw_n,
  inout  wire  [BYTE_W*BYTES-1:0]     mem_dq
);
  localparam int BEATS = sb4_pkg::BEATS;
  localparam int DW    = BYTE_W * BYTES;

  logic             ph;
  logic             accept_wr;
  logic [BEATS-1:0] cap, drv;
  logic [DW-1:0]    dq_out;
  logic             dq_oe;
  logic             cmd_any;

  sb4_kgen u_kgen (.clk(clk), .rst_n(rst_n), .ph(ph), .mem_k(mem_k));
  assign mem_kn = ~mem_k;

  sb4_sched #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_sched (
    .clk(clk), .rst_n(rst_n), .ph(ph),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .accept_wr(accept_wr),
    .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .cap(cap), .drv(drv)
  );

  sb4_wpath #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_wpath (
    .clk(clk), .rst_n(rst_n), .load(accept_wr),
    .wdata(req_wdata), .wbe(req_be), .drv(drv),
    .dq_out(dq_out), .dq_oe(dq_oe), .bw_n(mem_bw_n)
  );

  assign mem_dq = dq_oe ? dq_out : 'z;

  sb4_rpath #(.DW(DW)) u_rpath (
    .clk(clk), .rst_n(rst_n), .cap(cap), .dq_in(mem_dq),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign cmd_any = !mem_rd_n || !mem_wr_n;

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_any) |=> (cmd_any && $stable(mem_addr) && $stable(mem_rd_n)));  // R3
  AST_CMD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_any) |=> ##1 !cmd_any);  // R3
  AST_CMD_BEFORE_KRISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_any) |-> ph);  // R4
  AST_LATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(mem_wr_n, 2) == 1'b0));  // R5
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cap != '0) |-> !dq_oe);  // R8
endmodule

// File: tb/sram_b4_ctrl_bench.sv
module sram_b4_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int BW  = 9;
  localparam int NB  = 2;
  localparam int DW  = BW * NB;
  localparam int LAT = 3;
  localparam int NV  = 11;

  // {tag[36:35] (0:R7 1:R6 2:R1), wr[34], addr[33:26], be[25:18], seed[17:0]}
  localparam logic [36:0] VEC [0:NV-1] = '{
    {2'd0, 1'b1, 8'h10, 8'hFF, 18'h0A5A5},
    {2'd0, 1'b1, 8'h14, 8'hFF, 18'h13C01},
    {2'd0, 1'b0, 8'h10, 8'h00, 18'h00000},
    {2'd0, 1'b0, 8'h14, 8'h00, 18'h00000},
    {2'd0, 1'b1, 8'h10, 8'b10010011, 18'h2F00F},
    {2'd1, 1'b0, 8'h10, 8'h00, 18'h00000},
    {2'd2, 1'b1, 8'h23, 8'hFF, 18'h35A3C},
    {2'd2, 1'b0, 8'h21, 8'h00, 18'h00000},
    {2'd0, 1'b0, 8'h14, 8'h00, 18'h00000},
    {2'd1, 1'b1, 8'h14, 8'h00, 18'h3FFFF},
    {2'd1, 1'b0, 8'h14, 8'h00, 18'h00000}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_write;
  logic            req_ready;
  logic [AW-1:0]   req_addr;
  logic [4*DW-1:0] req_wdata;
  logic [4*NB-1:0] req_be;
  logic            rsp_valid;
  logic [4*DW-1:0] rsp_rdata;
  logic            mem_k, mem_kn, mem_rd_n, mem_wr_n;
  logic [AW-1:0]   mem_addr;
  logic [NB-1:0]   mem_bw_n;
  wire  [DW-1:0]   mem_dq;
  logic            men = 1'b0;
  logic [DW-1:0]   mdrv = '0;
  assign mem_dq = men ? mdrv : 'z;

  int checks = 0, errors = 0, cyc = 0, accepts = 0, mem_cmds = 0, ecnt = 0, slot;
  logic [DW-1:0]   mem [0:255];
  logic [DW-1:0]   ref_mem [0:255];
  bit              rs_v [16];
  logic [AW-1:0]   rs_a [16];
  bit              ws_v [16];
  logic [AW-1:0]   ws_a [16];
  logic [4*DW-1:0] exp_d [64];
  int              exp_c [64];
  string           exp_t [64];
  int              ewp = 0, erp = 0;

  sram_b4_ctrl #(.ADDR_W(AW), .BYTE_W(BW), .BYTES(NB), .RD_LAT(LAT)) u_sram_b4_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_k(mem_k), .mem_kn(mem_kn),
    .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_bw_n(mem_bw_n), .mem_dq(mem_dq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model: commands on rising mem_k, beats on both edges
  always @(posedge mem_k or negedge mem_k) begin
    if (rst_n) begin
      slot = ecnt % 16;
      if (ws_v[slot]) begin
        chk(!$isunknown(mem_dq), "R5 write beat defined", 128'(mem_dq), 128'(0));
        for (int l = 0; l < NB; l++)
          if (!mem_bw_n[l]) mem[ws_a[slot]][l*BW +: BW] = mem_dq[l*BW +: BW];
        ws_v[slot] = 1'b0;
      end
      if (rs_v[slot]) begin
        men = 1'b1; mdrv = mem[rs_a[slot]]; rs_v[slot] = 1'b0;
      end else begin
        men = 1'b0;
      end
      if (mem_k && (!mem_rd_n || !mem_wr_n)) begin
        mem_cmds++;
        chk(mem_addr[1:0] == 2'b00, "R1 aligned address", 128'(mem_addr), 128'(mem_addr & ~8'h3));
        for (int b = 0; b < 4; b++) begin
          if (!mem_rd_n) begin
            rs_v[(ecnt + LAT + b) % 16] = 1'b1; rs_a[(ecnt + LAT + b) % 16] = mem_addr + AW'(b);
          end else begin
            ws_v[(ecnt + 2 + b) % 16] = 1'b1; ws_a[(ecnt + 2 + b) % 16] = mem_addr + AW'(b);
          end
        end
      end
      ecnt++;
    end
  end

  // monitors, sampled a quarter period after the rising clk edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && men) chk(mem_dq === mdrv, "R8 bus contention", 128'(mem_dq), 128'(mdrv));
    if (rst_n && rsp_valid) begin
      if (erp == ewp) chk(1'b0, "R7 unexpected response", 128'(rsp_rdata), 128'(0));
      else begin
        chk(rsp_rdata === exp_d[erp % 64], exp_t[erp % 64], 128'(rsp_rdata), 128'(exp_d[erp % 64]));
        chk(cyc == exp_c[erp % 64], "R7 response cycle", 128'(cyc), 128'(exp_c[erp % 64]));
        erp++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      chk(1'b0, "R2 watchdog expired", 128'(cyc), 128'(20000));
      finish_sim();
    end
  end

  function automatic logic [4*DW-1:0] mk_data(input logic [17:0] seed);
    for (int b = 0; b < 4; b++) mk_data[b*DW +: DW] = seed + 18'(b * 4097);
  endfunction

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [4*DW-1:0] d,
                        input logic [4*NB-1:0] be, input string tag, output int acc);
    logic [AW-1:0] base;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    acc = cyc;
    accepts++;
    base = a & ~AW'(3);
    if (wr) begin
      for (int b = 0; b < 4; b++)
        for (int l = 0; l < NB; l++)
          if (be[b*NB + l]) ref_mem[base + AW'(b)][l*BW +: BW] = d[b*DW + l*BW +: BW];
    end else begin
      for (int b = 0; b < 4; b++) exp_d[ewp % 64][b*DW +: DW] = ref_mem[base + AW'(b)];
      exp_c[ewp % 64] = acc + LAT + 4;
      exp_t[ewp % 64] = tag;
      ewp++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    int a1, a2, a3, a4, a5, ones, togg;
    logic pk;
    string tg;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (6) @(negedge clk);
    chk(req_ready == 1'b0, "R2 ready low in reset", 128'(req_ready), 128'(0));
    chk(mem_rd_n && mem_wr_n, "R11 commands idle in reset", 128'({mem_rd_n, mem_wr_n}), 128'(3));
    chk(mem_bw_n == '1, "R6 byte selects idle in reset", 128'(mem_bw_n), 128'(3));
    chk(mem_dq === 'z, "R8 bus released in reset", 128'(mem_dq), 128'(0));
    chk(rsp_valid == 1'b0, "R11 no response in reset", 128'(rsp_valid), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    ones = 0; togg = 0; pk = mem_k;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #(CLK_PERIOD/4);
      if (req_ready) ones++;
      if (mem_k != pk) togg++;
      pk = mem_k;
      chk(mem_kn === ~mem_k, "R4 complement clock", 128'(mem_kn), 128'(~mem_k));
    end
    chk(ones == 4, "R2 ready on alternate cycles", 128'(ones), 128'(4));
    chk(togg == 8, "R4 clock toggles each cycle", 128'(togg), 128'(8));
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      tg = (VEC[i][36:35] == 2'd1) ? "R6 masked bytes" : (VEC[i][36:35] == 2'd2) ? "R1 aligned read" : "R7 read data";
      do_req(VEC[i][34], VEC[i][33:26], mk_data(VEC[i][17:0]), VEC[i][25:18], tg, a1);
    end
    repeat (20) @(negedge clk);

    do_req(1'b0, 8'h20, '0, '0, "R10 read stream", a1);
    do_req(1'b0, 8'h10, '0, '0, "R10 read stream", a2);
    do_req(1'b1, 8'h30, mk_data(18'h1D2E3), 8'hFF, "", a3);
    do_req(1'b1, 8'h34, mk_data(18'h07777), 8'h5A, "", a4);
    do_req(1'b0, 8'h30, '0, '0, "R9 read after write", a5);
    chk(a2 - a1 == 4, "R10 read after read spacing", 128'(a2 - a1), 128'(4));
    chk(a3 - a2 == 8, "R9 write after read spacing", 128'(a3 - a2), 128'(8));
    chk(a4 - a3 == 4, "R10 write after write spacing", 128'(a4 - a3), 128'(4));
    chk(a5 - a4 == 4, "R10 read after write spacing", 128'(a5 - a4), 128'(4));
    do_req(1'b0, 8'h34, '0, '0, "R6 masked bytes", a1);
    repeat (20) @(negedge clk);

    chk(mem_cmds == accepts, "R3 one command per request", 128'(mem_cmds), 128'(accepts));
    chk(erp == ewp, "R7 all responses returned", 128'(erp), 128'(ewp));
    chk(mem_dq === 'z, "R8 bus released when idle", 128'(mem_dq), 128'(0));
    chk(mem_bw_n == '1, "R6 byte selects idle", 128'(mem_bw_n), 128'(3));
    finish_sim();
  end
endmodule